// File: doc/BRIEF.md
# Balanced-Ternary General-Purpose Register File

This block stores the general-purpose registers of a balanced-ternary processor. Each word is 20 trits. Every trit is held as a 2-bit binary code, so a word occupies 40 bits. There are 27 entries. Three combinational read ports serve instructions that take three source operands. One clocked write port accepts the destination result.

A second write path, the link port, always targets entry 26. A call uses it to save its return address, and it can run in the same cycle as the normal write. Entry 0 is a constant zero. A write aimed at it, or at an index that names no register, does not happen. Instead the `fault` output pulses so that the pipeline can trap.

Top module: `tern_regfile`

## Requirements
- R1: After reset, every index 0..26 reads the all-zero-trit word, which is code 01 repeated in every trit.
- R2: Trit i of a word sits at bits [2i+1:2i], least significant trit first, coded minus=00, zero=01, plus=10. A written word is stored and read back bit for bit.
- R3: A write with `wr_en` high to an index from 1 to 25 updates that entry at the rising clock edge. No other entry changes.
- R4: The three read ports are combinational and independent of each other. There is no bypass: in the cycle of a write, a read of the same index returns the old contents.
- R5: Index 0 reads the zero word on every port at all times.
- R6: A write to index 0 changes no entry and raises `fault` for exactly the one cycle after the edge that rejected it.
- R7: A write to an index from 27 to 31 changes no entry and raises the same one-cycle `fault` pulse.
- R8: Reading an index from 27 to 31 returns the zero word.
- R9: With `lnk_en` high, `lnk_data` is written to entry 26 without a fault. A normal write to index 26 with the link port idle also lands there.
- R10: When the link port and a normal write both target entry 26 in the same cycle, the link value wins.
- R11: When the link port and a normal write to another legal index occur in the same cycle, both take effect.
- R12: `fault` stays low after legal writes and after idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Destination write enable |
| wr_idx | input | 5 | Destination index, binary 0..31 |
| wr_data | input | 40 | Destination word, 20 trits of 2 bits |
| lnk_en | input | 1 | Link write enable, targets entry 26 |
| lnk_data | input | 40 | Link word |
| rd_idx_a | input | 5 | Source A index |
| rd_idx_b | input | 5 | Source B index |
| rd_idx_c | input | 5 | Source C index |
| rd_data_a | output | 40 | Source A word |
| rd_data_b | output | 40 | Source B word |
| rd_data_c | output | 40 | Source C word |
| fault | output | 1 | One-cycle pulse after a rejected write |

## Verification
The assertions run on every cycle. They check four things:
- Index 0 reads as zero on port A.
- A fault pulse always traces back to an illegal write in the previous cycle.
- A legal write never raises a fault.
- A rejected write leaves the whole storage unchanged, and a link write lands in entry 26.

Only the bench scenarios can show some behaviours:
- Each of the 26 writable entries holds a distinct computed value without disturbing the others.
- The missing bypass is visible within the write cycle.
- All three ports agree for every index.
- Link and normal writes interact correctly when both occur in one cycle.

// File: rtl/tern_regfile.sv
module tern_regfile #(
  parameter int NTRIT    = 20,
  parameter int NREG     = 27,
  parameter int IDXW     = 5,
  parameter int LINK_REG = 26
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDXW-1:0]      wr_idx,
  input  logic [2*NTRIT-1:0]   wr_data,
  input  logic                 lnk_en,
  input  logic [2*NTRIT-1:0]   lnk_data,
  input  logic [IDXW-1:0]      rd_idx_a,
  input  logic [IDXW-1:0]      rd_idx_b,
  input  logic [IDXW-1:0]      rd_idx_c,
  output logic [2*NTRIT-1:0]   rd_data_a,
  output logic [2*NTRIT-1:0]   rd_data_b,
  output logic [2*NTRIT-1:0]   rd_data_c,
  output logic                 fault
);
  localparam int W = 2 * NTRIT;
  localparam logic [W-1:0]    ZERO_WORD = {NTRIT{2'b01}};
  localparam logic [IDXW-1:0] TOP_IDX   = IDXW'(NREG);

  logic [NREG-1:0][W-1:0] words;
  logic                   bad_wr;

  assign words[0] = ZERO_WORD;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    localparam logic [IDXW-1:0] MY_IDX = IDXW'(g);
    localparam bit              IS_LNK = (g == LINK_REG);
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= ZERO_WORD;
      else if (IS_LNK && lnk_en)
        q <= lnk_data;
      else if (wr_en && wr_idx == MY_IDX)
        q <= wr_data;
    end
    assign words[g] = q;
  end

  assign rd_data_a = (rd_idx_a < TOP_IDX) ? words[rd_idx_a] : ZERO_WORD;
  assign rd_data_b = (rd_idx_b < TOP_IDX) ? words[rd_idx_b] : ZERO_WORD;
  assign rd_data_c = (rd_idx_c < TOP_IDX) ? words[rd_idx_c] : ZERO_WORD;

  assign bad_wr = wr_en && (wr_idx == '0 || wr_idx >= TOP_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault <= 1'b0;
    else        fault <= bad_wr;
  end

  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx_a == '0 |-> rd_data_a == ZERO_WORD); // R5

  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(wr_en) && ($past(wr_idx) == '0 || $past(wr_idx) >= TOP_IDX)); // R6

  AST_GOOD_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_idx != '0 && wr_idx < TOP_IDX |=> !fault); // R12

  AST_REJECT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr && !lnk_en |=> $stable(words)); // R7

  AST_LINK_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_en |=> words[LINK_REG] == $past(lnk_data)); // R10
endmodule

// File: tb/tb_tern_regfile.sv
`timescale 1ns/1ps
module tb_tern_regfile;
  localparam int NT = 20;
  localparam int W  = 2 * NT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, lnk_en = 1'b0;
  logic [4:0] wr_idx = '0, rd_idx_a = '0, rd_idx_b = '0, rd_idx_c = '0;
  logic [W-1:0] wr_data = '0, lnk_data = '0;
  logic [W-1:0] rd_data_a, rd_data_b, rd_data_c;
  logic fault;

  int errors = 0, checks = 0;
  logic [W-1:0] model [0:31];

  always #4 clk = ~clk;

  tern_regfile dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .lnk_en(lnk_en), .lnk_data(lnk_data), .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
    .rd_idx_c(rd_idx_c), .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
    .rd_data_c(rd_data_c), .fault(fault));

  function automatic logic [W-1:0] enc(input int v);
    logic [W-1:0] r;
    int x;
    x = v;
    for (int i = 0; i < NT; i++) begin
      int m;
      m = ((x % 3) + 3) % 3;
      if (m == 0)      begin r[2*i +: 2] = 2'b01; x = x / 3; end
      else if (m == 1) begin r[2*i +: 2] = 2'b10; x = (x - 1) / 3; end
      else             begin r[2*i +: 2] = 2'b00; x = (x + 1) / 3; end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int i = 0; i < 32; i++) begin
      rd_idx_a = 5'(i); rd_idx_b = 5'((i + 11) % 32); rd_idx_c = 5'((i + 23) % 32);
      #1;
      chk(req, rd_data_a, model[i]);
      chk(req, rd_data_b, model[(i + 11) % 32]);
      chk(req, rd_data_c, model[(i + 23) % 32]);
    end
  endtask

  task automatic do_write(input int idx, input logic [W-1:0] d, input logic lnk,
                          input logic [W-1:0] ld, input logic exp_fault, input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_data = d; lnk_en = lnk; lnk_data = ld;
    @(negedge clk);
    wr_en = 1'b0; lnk_en = 1'b0;
    checks++;
    if (fault !== exp_fault) begin
      errors++;
      $display("FAIL %s fault: actual=%0b expected=%0b", req, fault, exp_fault);
    end
    @(negedge clk);
    checks++;
    if (fault !== 1'b0) begin
      errors++;
      $display("FAIL %s pulse width: actual=%0b expected=0", req, fault);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = {NT{2'b01}};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (fault !== 1'b0) begin errors++; $display("FAIL R1 fault: actual=%0b expected=0", fault); end
    chk_all("R1");

    // R2 R3 R9: sweep all writable entries with computed values
    for (int k = 1; k < 27; k++) begin
      int v;
      v = k * 61234567 - 900000000;
      model[k] = enc(v);
      do_write(k, model[k], 1'b0, '0, 1'b0, (k == 26) ? "R9" : "R3");
      chk_all("R3");
    end
    // R2 extremes and known pattern: +1 is trit0=10, rest 01; -1 trit0=00
    chk("R2", enc(1), {{(NT-1){2'b01}}, 2'b10});
    chk("R2", enc(-1), {{(NT-1){2'b01}}, 2'b00});
    model[7] = {NT{2'b10}};
    do_write(7, model[7], 1'b0, '0, 1'b0, "R2");
    model[8] = {NT{2'b00}};
    do_write(8, model[8], 1'b0, '0, 1'b0, "R2");
    chk_all("R2");

    // R4: no bypass
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd5; wr_data = enc(4242); rd_idx_a = 5'd5; rd_idx_b = 5'd5; rd_idx_c = 5'd5;
    #1;
    chk("R4", rd_data_a, model[5]);
    chk("R4", rd_data_b, model[5]);
    chk("R4", rd_data_c, model[5]);
    @(negedge clk);
    wr_en = 1'b0;
    model[5] = enc(4242);
    chk("R4", rd_data_a, model[5]);

    // R6 / R5: write to zero
    do_write(0, enc(777), 1'b0, '0, 1'b1, "R6");
    chk_all("R5");

    // R7 / R8: writes to 27..31
    for (int k = 27; k < 32; k++) begin
      do_write(k, enc(k * 1000), 1'b0, '0, 1'b1, "R7");
      chk_all("R8");
    end

    // R9: link alone
    model[26] = enc(-123456789);
    do_write(3, model[3], 1'b1, model[26], 1'b0, "R9");
    chk_all("R9");

    // R10: link beats normal write to 26
    model[26] = enc(55555);
    do_write(26, enc(-1), 1'b1, model[26], 1'b0, "R10");
    chk_all("R10");

    // R11: link + another legal index
    model[26] = enc(31337);
    model[12] = enc(-31337);
    do_write(12, model[12], 1'b1, model[26], 1'b0, "R11");
    chk_all("R11");

    // R6 with link: rejected normal write, link still lands
    model[26] = enc(99);
    do_write(0, enc(5), 1'b1, model[26], 1'b1, "R6");
    chk_all("R6");

    // R12: idle cycles keep fault low
    repeat (4) begin
      @(negedge clk);
      checks++;
      if (fault !== 1'b0) begin errors++; $display("FAIL R12: actual=%0b expected=0", fault); end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule